// File: doc/BRIEF.md
# Multicycle 24-bit Accumulator Processor

This block is a small accumulator processor. Its data word is 24 bits wide and its memory space is 32K bytes. A word takes three consecutive bytes and is named by its lowest byte address, with the most significant byte first. The core holds an accumulator, an index register, a linkage register, a program counter and a condition code. It steps through each instruction over several cycles and uses one byte-wide synchronous memory port for both fetches and data.

Each instruction is three bytes long: an 8-bit opcode, an index flag, and a 15-bit address field. The core runs loads, stores, four integer operations, compare, an unconditional jump, three conditional jumps, and subroutine call and return. It also drives a byte-wide device port. There, software polls a device for readiness and then reads a byte into the accumulator or writes a byte from it. An opcode the core does not know stops it for good, until the next reset.

Top module: `acc_core`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `halted`, `div_err`, `mem_wr`, `dev_rd` and `dev_wr` are low and `mem_addr` is 0. Execution starts at address 0.
- R2: An instruction is fetched as three bytes from PC, PC+1 and PC+2, most significant first. Bits 23:16 are the opcode, bit 15 is the index flag and bits 14:0 are the address field. PC then advances by 3. The opcodes are LDA 00, LDX 04, LDL 08, STA 0C, STX 10, STL 14, ADD 18, SUB 1C, MUL 20, DIV 24, COMP 28, JEQ 30, JGT 34, JLT 38, J 3C, JSUB 48, RSUB 4C, RD D8, WD DC and TD E0, all in hex. A memory operand word is read with the same big-endian order.
- R3: With the index flag at 0, the target address is the address field. With it at 1, the target address is the address field plus the low 15 bits of X, modulo 2^15.
- R4: STA, STX and STL write the 24-bit register as three bytes to the target address and the next two addresses, most significant byte first. The core writes one byte per cycle, with `mem_wr` high on consecutive addresses.
- R5: ADD, SUB and MUL put the low 24 bits of A+M, A-M and A*M into A. DIV puts the signed quotient of A by M, truncated toward zero, into A.
- R6: DIV with a zero memory word leaves A unchanged and sets `div_err`. `div_err` then stays high until reset.
- R7: COMP compares A with M as signed numbers. JLT, JEQ and JGT jump only when the condition code holds less, equal or greater. J always jumps.
- R8: JSUB puts the address of the next instruction in L and jumps to the target. RSUB jumps to the address held in L.
- R9: TD, RD and WD place the low 8 bits of the address field on `dev_code`. TD sets the condition code to less when `dev_ready` is high and to equal when it is low. Each device strobe lasts one cycle.
- R10: RD replaces bits 7:0 of A with `dev_rdata` and keeps bits 23:8. WD pulses `dev_wr` with bits 7:0 of A on `dev_wdata`.
- R11: An unknown opcode sets `halted`. `halted` stays high until reset, and after that no memory write or device strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 15 | Byte address for a read or write |
| mem_wr | output | 1 | Write strobe for one byte |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid one cycle after its address |
| dev_code | output | 8 | Selected device number |
| dev_rd | output | 1 | One-cycle device read strobe |
| dev_wr | output | 1 | One-cycle device write strobe |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_rdata | input | 8 | Byte from the device, sampled while `dev_rd` is high |
| dev_ready | input | 1 | Device readiness, sampled by TD |
| halted | output | 1 | Core stopped on an unknown opcode |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
The assertions check these rules on every cycle:
- the halt and divide-error flags stay set once raised;
- a halted core stays quiet;
- the memory write strobe and the two device strobes never overlap;
- device strobes last a single cycle;
- the bytes of a store land on consecutive addresses;
- the port state is clean after reset.

Arithmetic results, the signed compare and jump choice, indexed target addresses, big-endian byte order, subroutine linkage, and the polling of a device that becomes ready late can only be shown by the bench's programs. The bench checks these through the words the programs store back to memory and the bytes written to the device.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam logic [7:0] OP_LDA  = 8'h00;
  localparam logic [7:0] OP_LDX  = 8'h04;
  localparam logic [7:0] OP_LDL  = 8'h08;
  localparam logic [7:0] OP_STA  = 8'h0C;
  localparam logic [7:0] OP_STX  = 8'h10;
  localparam logic [7:0] OP_STL  = 8'h14;
  localparam logic [7:0] OP_ADD  = 8'h18;
  localparam logic [7:0] OP_SUB  = 8'h1C;
  localparam logic [7:0] OP_MUL  = 8'h20;
  localparam logic [7:0] OP_DIV  = 8'h24;
  localparam logic [7:0] OP_COMP = 8'h28;
  localparam logic [7:0] OP_JEQ  = 8'h30;
  localparam logic [7:0] OP_JGT  = 8'h34;
  localparam logic [7:0] OP_JLT  = 8'h38;
  localparam logic [7:0] OP_J    = 8'h3C;
  localparam logic [7:0] OP_JSUB = 8'h48;
  localparam logic [7:0] OP_RSUB = 8'h4C;
  localparam logic [7:0] OP_RD   = 8'hD8;
  localparam logic [7:0] OP_WD   = 8'hDC;
  localparam logic [7:0] OP_TD   = 8'hE0;

  localparam logic [1:0] CC_EQ = 2'd0;
  localparam logic [1:0] CC_LT = 2'd1;
  localparam logic [1:0] CC_GT = 2'd2;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_LOAD, ST_EXEC, ST_STORE, ST_IO, ST_HALT
  } core_state_e;

  function automatic logic needs_operand(input logic [7:0] op);
    return (op == OP_LDA) || (op == OP_LDX) || (op == OP_LDL) ||
           (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) ||
           (op == OP_DIV) || (op == OP_COMP);
  endfunction

  function automatic logic is_store(input logic [7:0] op);
    return (op == OP_STA) || (op == OP_STX) || (op == OP_STL);
  endfunction

  function automatic logic is_device(input logic [7:0] op);
    return (op == OP_TD) || (op == OP_RD) || (op == OP_WD);
  endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int WORD_W = 24
) (
  input  logic [7:0]        op,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] opnd,
  output logic [WORD_W-1:0] result,
  output logic              div_zero,
  output logic [1:0]        cmp_cc
);
  import acc_pkg::*;

  logic [2*WORD_W-1:0]        prod;
  logic signed [WORD_W-1:0]   quot;

  always_comb begin
    prod     = {{WORD_W{1'b0}}, acc} * {{WORD_W{1'b0}}, opnd};
    quot     = '0;
    result   = acc;
    div_zero = 1'b0;
    case (op)
      OP_ADD: result = acc + opnd;
      OP_SUB: result = acc - opnd;
      OP_MUL: result = prod[WORD_W-1:0];
      OP_DIV: begin
        if (opnd == '0) begin
          div_zero = 1'b1;
        end else begin
          quot   = $signed(acc) / $signed(opnd);
          result = quot;
        end
      end
      default: result = acc;
    endcase
  end

  always_comb begin
    if ($signed(acc) < $signed(opnd))  cmp_cc = CC_LT;
    else if (acc == opnd)              cmp_cc = CC_EQ;
    else                               cmp_cc = CC_GT;
  end

endmodule

// File: rtl/acc_ea.sv
module acc_ea #(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] field,
  input  logic              use_index,
  input  logic [ADDR_W-1:0] index_low,
  output logic [ADDR_W-1:0] target
);
  assign target = field + (use_index ? index_low : '0);
endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 15,
  parameter int DEV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [DEV_W-1:0]  dev_code,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata,
  input  logic              dev_ready,
  output logic              halted,
  output logic              div_err
);
  import acc_pkg::*;

  localparam int NB = WORD_W / 8;
  localparam int CW = $clog2(NB + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(NB);
  localparam logic [CW-1:0] CNT_STLAST = CW'(NB - 1);

  core_state_e       state_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] a_q, x_q, l_q, pc_q, ir_q, md_q;
  logic [1:0]        cc_q;
  logic [ADDR_W-1:0] ta_q;
  logic              halted_q, div_err_q;
  logic [DEV_W-1:0]  dev_code_q;
  logic              dev_rd_q, dev_wr_q;
  logic [7:0]        dev_wdata_q;

  logic [7:0]        op;
  logic              idx;
  logic [ADDR_W-1:0] field;
  logic [ADDR_W-1:0] ta_w;
  logic [WORD_W-1:0] alu_res;
  logic              alu_dz;
  logic [1:0]        alu_cc;
  logic [WORD_W-1:0] st_src;

  assign op    = ir_q[WORD_W-1 -: 8];
  assign idx   = ir_q[ADDR_W];
  assign field = ir_q[ADDR_W-1:0];

  acc_ea #(.ADDR_W(ADDR_W)) u_ea (
    .field     (field),
    .use_index (idx),
    .index_low (x_q[ADDR_W-1:0]),
    .target    (ta_w)
  );

  acc_alu #(.WORD_W(WORD_W)) u_alu (
    .op       (op),
    .acc      (a_q),
    .opnd     (md_q),
    .result   (alu_res),
    .div_zero (alu_dz),
    .cmp_cc   (alu_cc)
  );

  // Byte address: fetch walks PC, operand phases walk the target.
  always_comb begin
    case (state_q)
      ST_FETCH:          mem_addr = pc_q[ADDR_W-1:0] + ADDR_W'(cnt_q);
      ST_LOAD, ST_STORE: mem_addr = ta_q + ADDR_W'(cnt_q);
      default:           mem_addr = pc_q[ADDR_W-1:0];
    endcase
  end

  always_comb begin
    case (op)
      OP_STX:  st_src = x_q;
      OP_STL:  st_src = l_q;
      default: st_src = a_q;
    endcase
  end

  // Most significant byte leaves first.
  always_comb begin
    mem_wdata = '0;
    for (int k = 0; k < NB; k++) begin
      if (cnt_q == CW'(k)) mem_wdata = st_src[8*(NB-1-k) +: 8];
    end
  end

  assign mem_wr    = (state_q == ST_STORE);
  assign dev_code  = dev_code_q;
  assign dev_rd    = dev_rd_q;
  assign dev_wr    = dev_wr_q;
  assign dev_wdata = dev_wdata_q;
  assign halted    = halted_q;
  assign div_err   = div_err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_FETCH;
      cnt_q       <= '0;
      a_q         <= '0;
      x_q         <= '0;
      l_q         <= '0;
      pc_q        <= '0;
      ir_q        <= '0;
      md_q        <= '0;
      cc_q        <= CC_EQ;
      ta_q        <= '0;
      halted_q    <= 1'b0;
      div_err_q   <= 1'b0;
      dev_code_q  <= '0;
      dev_rd_q    <= 1'b0;
      dev_wr_q    <= 1'b0;
      dev_wdata_q <= '0;
    end else begin
      dev_rd_q <= 1'b0;
      dev_wr_q <= 1'b0;
      case (state_q)
        ST_FETCH: begin
          if (cnt_q != '0) ir_q <= {ir_q[WORD_W-9:0], mem_rdata};
          if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            pc_q    <= pc_q + WORD_W'(NB);
            state_q <= ST_DECODE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DECODE: begin
          ta_q    <= ta_w;
          cnt_q   <= '0;
          state_q <= ST_FETCH;
          if (needs_operand(op)) begin
            state_q <= ST_LOAD;
          end else if (is_store(op)) begin
            state_q <= ST_STORE;
          end else if (is_device(op)) begin
            dev_code_q  <= field[DEV_W-1:0];
            dev_rd_q    <= (op == OP_RD);
            dev_wr_q    <= (op == OP_WD);
            dev_wdata_q <= a_q[7:0];
            state_q     <= ST_IO;
          end else begin
            case (op)
              OP_J:    pc_q <= WORD_W'(ta_w);
              OP_JEQ:  if (cc_q == CC_EQ) pc_q <= WORD_W'(ta_w);
              OP_JLT:  if (cc_q == CC_LT) pc_q <= WORD_W'(ta_w);
              OP_JGT:  if (cc_q == CC_GT) pc_q <= WORD_W'(ta_w);
              OP_JSUB: begin
                l_q  <= pc_q;
                pc_q <= WORD_W'(ta_w);
              end
              OP_RSUB: pc_q <= l_q;
              default: begin
                halted_q <= 1'b1;
                state_q  <= ST_HALT;
              end
            endcase
          end
        end
        ST_LOAD: begin
          if (cnt_q != '0) md_q <= {md_q[WORD_W-9:0], mem_rdata};
          if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            state_q <= ST_EXEC;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_EXEC: begin
          state_q <= ST_FETCH;
          case (op)
            OP_LDA:  a_q <= md_q;
            OP_LDX:  x_q <= md_q;
            OP_LDL:  l_q <= md_q;
            OP_COMP: cc_q <= alu_cc;
            default: begin
              a_q       <= alu_res;
              div_err_q <= div_err_q | alu_dz;
            end
          endcase
        end
        ST_STORE: begin
          if (cnt_q == CNT_STLAST) begin
            cnt_q   <= '0;
            state_q <= ST_FETCH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_IO: begin
          state_q <= ST_FETCH;
          if (op == OP_TD) cc_q <= dev_ready ? CC_LT : CC_EQ;
          if (op == OP_RD) a_q[7:0] <= dev_rdata;
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wr,
  input logic              dev_rd,
  input logic              dev_wr,
  input logic              halted,
  input logic              div_err
);

  a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!halted && !div_err && !mem_wr && !dev_rd && !dev_wr && mem_addr == '0));

  a_r4_store_consecutive: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    div_err |=> div_err);

  a_r9_rd_single: assert property (@(posedge clk) disable iff (rst)
    dev_rd |=> !dev_rd);

  a_r9_wr_single: assert property (@(posedge clk) disable iff (rst)
    dev_wr |=> !dev_wr);

  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr, dev_rd, dev_wr}));

  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_wr && !dev_rd && !dev_wr));

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .mem_wr   (mem_wr),
  .dev_rd   (dev_rd),
  .dev_wr   (dev_wr),
  .halted   (halted),
  .div_err  (div_err)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] mem_addr;
  logic        mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic [7:0]  dev_code;
  logic        dev_rd, dev_wr;
  logic [7:0]  dev_wdata;
  logic [7:0]  dev_rdata = 8'h00;
  logic        dev_ready = 1'b0;
  logic        halted, div_err;

  logic [7:0]  mem [0:4095];
  int checks = 0;
  int failures = 0;
  int quiet_err, early_rd, wd_cnt;
  logic [7:0] wd_code, wd_data, rd_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_code(dev_code),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .dev_ready(dev_ready), .halted(halted),
    .div_err(div_err)
  );

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr) mem[mem_addr[11:0]] = mem_wdata;
    if (rst) begin
      quiet_err <= 0; early_rd <= 0; wd_cnt <= 0;
      wd_code <= 8'h00; wd_data <= 8'h00; rd_code <= 8'h00;
    end else begin
      if (halted && (mem_wr || dev_rd || dev_wr)) quiet_err <= quiet_err + 1;
      if (dev_rd && !dev_ready) early_rd <= early_rd + 1;
      if (dev_rd) rd_code <= dev_code;
      if (dev_wr) begin
        wd_cnt <= wd_cnt + 1; wd_code <= dev_code; wd_data <= dev_wdata;
      end
    end
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
  endtask

  task automatic put_ins(input int adr, input logic [7:0] op, input logic x, input logic [14:0] fld);
    mem[adr] = op; mem[adr+1] = {x, fld[14:8]}; mem[adr+2] = fld[7:0];
  endtask

  task automatic put_word(input int adr, input logic [23:0] w);
    mem[adr] = w[23:16]; mem[adr+1] = w[15:8]; mem[adr+2] = w[7:0];
  endtask

  function automatic logic [23:0] get_word(input int adr);
    return {mem[adr], mem[adr+1], mem[adr+2]};
  endfunction

  function automatic logic [23:0] f_div(input logic [23:0] a, input logic [23:0] b);
    int sa, sb;
    sa = $signed(a); sb = $signed(b);
    return 24'(sa / sb);
  endfunction

  function automatic logic [23:0] f_mul(input logic [23:0] a, input logic [23:0] b);
    longint p;
    p = longint'(a) * longint'(b);
    return p[23:0];
  endfunction

  function automatic logic [23:0] f_cmp(input logic [23:0] a, input logic [23:0] b);
    int sa, sb;
    sa = $signed(a); sb = $signed(b);
    return (sa < sb) ? 24'd1 : (sa == sb) ? 24'd2 : 24'd3;
  endfunction

  // Reset, release, and run until halt; ready rises ready_after cycles in.
  task automatic run_prog(input int ready_after, input string req);
    int n;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (!halted && n < 4000) begin
      if (n == ready_after) dev_ready = 1'b1;
      @(negedge clk);
      n++;
    end
    check({req, " halts"}, 24'(halted), 24'd1);
  endtask

  initial begin
    logic [23:0] va, vb;
    void'($urandom(32'd1234));

    // R1: reset state
    clear_mem();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 halted", 24'(halted), 24'd0);
    check("R1 div_err", 24'(div_err), 24'd0);
    check("R1 strobes", 24'({mem_wr, dev_rd, dev_wr}), 24'd0);
    check("R1 mem_addr", 24'(mem_addr), 24'd0);

    // R5: arithmetic, random operands
    for (int it = 0; it < 8; it++) begin
      va = 24'($urandom); vb = 24'($urandom);
      if (it == 0) begin va = 24'h7FFFFF; vb = 24'h000001; end
      if (it == 1) begin va = 24'hFFFFF9; vb = 24'h000002; end
      if (vb == 24'd0) vb = 24'd1;
      if (va == 24'h800000 && vb == 24'hFFFFFF) vb = 24'd2;
      clear_mem();
      put_word(12'h100, va); put_word(12'h103, vb);
      put_ins(0, 8'h00, 0, 15'h100); put_ins(3, 8'h18, 0, 15'h103); put_ins(6, 8'h0C, 0, 15'h200);
      put_ins(9, 8'h00, 0, 15'h100); put_ins(12, 8'h1C, 0, 15'h103); put_ins(15, 8'h0C, 0, 15'h203);
      put_ins(18, 8'h00, 0, 15'h100); put_ins(21, 8'h20, 0, 15'h103); put_ins(24, 8'h0C, 0, 15'h206);
      put_ins(27, 8'h00, 0, 15'h100); put_ins(30, 8'h24, 0, 15'h103); put_ins(33, 8'h0C, 0, 15'h209);
      run_prog(0, "R5");
      check("R5 ADD", get_word(12'h200), va + vb);
      check("R5 SUB", get_word(12'h203), va - vb);
      check("R5 MUL", get_word(12'h206), f_mul(va, vb));
      check("R5 DIV", get_word(12'h209), f_div(va, vb));
      check("R6 no div_err on nonzero divisor", 24'(div_err), 24'd0);
      check("R11 quiet after halt", 24'(quiet_err), 24'd0);
    end

    // R7: compare and conditional jumps
    for (int it = 0; it < 8; it++) begin
      va = 24'($urandom); vb = 24'($urandom);
      if (it == 0) vb = va;
      if (it == 1) begin va = 24'h800000; vb = 24'h000001; end
      if (it == 2) begin va = 24'h000005; vb = 24'hFFFFFF; end
      clear_mem();
      put_word(12'h100, va); put_word(12'h103, vb);
      put_word(12'h109, 24'd9); put_word(12'h10C, 24'd1);
      put_word(12'h10F, 24'd2); put_word(12'h112, 24'd3);
      put_ins(0, 8'h00, 0, 15'h100); put_ins(3, 8'h28, 0, 15'h103);
      put_ins(6, 8'h38, 0, 15'h030); put_ins(9, 8'h30, 0, 15'h040);
      put_ins(12, 8'h34, 0, 15'h050);
      put_ins(15, 8'h00, 0, 15'h109); put_ins(18, 8'h0C, 0, 15'h200);
      put_ins(12'h30, 8'h00, 0, 15'h10C); put_ins(12'h33, 8'h0C, 0, 15'h200);
      put_ins(12'h40, 8'h00, 0, 15'h10F); put_ins(12'h43, 8'h0C, 0, 15'h200);
      put_ins(12'h50, 8'h00, 0, 15'h112); put_ins(12'h53, 8'h0C, 0, 15'h200);
      run_prog(0, "R7");
      check("R7 branch taken", get_word(12'h200), f_cmp(va, vb));
    end

    // R6: divide by zero, then R1 clears the flag on reset
    clear_mem();
    put_word(12'h100, 24'h000123); put_word(12'h103, 24'h000000);
    put_ins(0, 8'h00, 0, 15'h100); put_ins(3, 8'h24, 0, 15'h103); put_ins(6, 8'h0C, 0, 15'h200);
    run_prog(0, "R6");
    check("R6 A unchanged", get_word(12'h200), 24'h000123);
    check("R6 div_err set", 24'(div_err), 24'd1);
    repeat (5) @(negedge clk);
    check("R6 div_err sticky", 24'(div_err), 24'd1);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 div_err cleared by reset", 24'(div_err), 24'd0);

    // R3 and R4: indexed load/store, big-endian bytes, STX
    clear_mem();
    put_word(12'h120, 24'd6); put_word(12'h100, 24'h111111); put_word(12'h106, 24'hABCDEF);
    put_word(12'h200, 24'h000000); put_word(12'h206, 24'h000000);
    put_ins(0, 8'h04, 0, 15'h120); put_ins(3, 8'h00, 1, 15'h100);
    put_ins(6, 8'h0C, 1, 15'h200); put_ins(9, 8'h10, 0, 15'h210);
    run_prog(0, "R3");
    check("R3 indexed store target", get_word(12'h206), 24'hABCDEF);
    check("R3 unindexed word untouched", get_word(12'h200), 24'h000000);
    check("R4 byte order msb", 24'(mem[12'h206]), 24'h0000AB);
    check("R4 byte order lsb", 24'(mem[12'h208]), 24'h0000EF);
    check("R4 STX word", get_word(12'h210), 24'd6);
    check("R2 next byte after store untouched", 24'(mem[12'h209]), 24'h0000FF);

    // R8: subroutine call and return
    clear_mem();
    put_word(12'h100, 24'h5E5E5E);
    put_ins(0, 8'h48, 0, 15'h040);
    put_ins(12'h40, 8'h14, 0, 15'h210); put_ins(12'h43, 8'h00, 0, 15'h100);
    put_ins(12'h46, 8'h0C, 0, 15'h213); put_ins(12'h49, 8'h4C, 0, 15'h000);
    run_prog(0, "R8");
    check("R8 L holds return address", get_word(12'h210), 24'd3);
    check("R8 subroutine body ran", get_word(12'h213), 24'h5E5E5E);

    // R9 and R10: poll a device that becomes ready late, read then write
    clear_mem();
    dev_ready = 1'b0; dev_rdata = 8'hC3;
    put_word(12'h100, 24'h5A5A00);
    put_ins(0, 8'h00, 0, 15'h100); put_ins(3, 8'hE0, 0, 15'h005);
    put_ins(6, 8'h30, 0, 15'h003); put_ins(9, 8'hD8, 0, 15'h005);
    put_ins(12, 8'h0C, 0, 15'h200); put_ins(15, 8'hDC, 0, 15'h007);
    run_prog(80, "R9");
    check("R9 no read before ready", 24'(early_rd), 24'd0);
    check("R9 read device code", 24'(rd_code), 24'h000005);
    check("R10 RD keeps upper A", get_word(12'h200), 24'h5A5AC3);
    check("R10 one write strobe", 24'(wd_cnt), 24'd1);
    check("R10 write code", 24'(wd_code), 24'h000007);
    check("R10 write data", 24'(wd_data), 24'h0000C3);

    // R9: ready device sets less-than
    clear_mem();
    dev_ready = 1'b1;
    put_word(12'h10C, 24'd1); put_word(12'h10F, 24'd2);
    put_ins(0, 8'hE0, 0, 15'h005); put_ins(3, 8'h38, 0, 15'h030);
    put_ins(6, 8'h00, 0, 15'h10F); put_ins(9, 8'h0C, 0, 15'h200);
    put_ins(12'h30, 8'h00, 0, 15'h10C); put_ins(12'h33, 8'h0C, 0, 15'h200);
    run_prog(0, "R9");
    check("R9 ready gives less-than", get_word(12'h200), 24'd1);

    // R11: unknown opcode close to a valid one stops the core
    clear_mem();
    put_word(12'h200, 24'h123456);
    put_ins(0, 8'h01, 0, 15'h100); put_ins(3, 8'h0C, 0, 15'h200);
    run_prog(0, "R11");
    repeat (20) @(negedge clk);
    check("R11 halted stays", 24'(halted), 24'd1);
    check("R11 later store not run", get_word(12'h200), 24'h123456);
    check("R11 quiet after halt", 24'(quiet_err), 24'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule